// File: doc/BRIEF.md
# Parallel Converter Byte-Read Sequencer

This block sits on the host side of a 12-bit converter whose result comes out on an 8-bit three-state bus. On a sample request it selects the converter and holds the active-low start strobe for a set number of cycles. It then waits for the converter's active-low busy flag to go low and come back high. After that it reads the result in two bus cycles. The first read sets the byte-select line high and takes the top four result bits from the lowest four data lines. The second read sets byte-select low and takes the low eight bits. The assembled word is handed out with a one-cycle valid pulse. It is given either as raw straight binary or, in bipolar mode, as two's complement.

The sequencer also controls the converter's two power-down modes, nap and sleep. When nap is released, it counts a fixed number of wake-up cycles before it accepts a new request. When sleep is released, it holds off until the converter's reference-ready input is high. If the busy flag does not complete a low-then-high cycle in time, a timeout pulse is raised and the converter is deselected.

The state machine has these states:
- IDLE
- SLEEP
- REF_WAIT
- NAP
- NAP_WAKE
- SETUP
- STROBE
- BUSY_WAIT
- READ_HI
- READ_GAP
- READ_LO
- DONE

It has these transitions:
- IDLE→SLEEP when a sleep request is present.
- IDLE→NAP when a nap request is present and no sleep request is.
- IDLE→SETUP on an accepted sample request.
- SLEEP→REF_WAIT when the sleep request is released.
- REF_WAIT→IDLE when reference-ready is high.
- NAP→NAP_WAKE when the nap request is released.
- NAP_WAKE→IDLE after NAP_WAKE_CYC cycles.
- SETUP→STROBE after SETUP_CYC cycles.
- STROBE→BUSY_WAIT after STROBE_CYC cycles.
- BUSY_WAIT→READ_HI once busy has been seen low and is now high.
- BUSY_WAIT→IDLE on timeout.
- READ_HI→READ_GAP after ACCESS_CYC cycles.
- READ_GAP→READ_LO after one cycle.
- READ_LO→DONE after ACCESS_CYC cycles.
- DONE→IDLE after one cycle.

Top module: `adc_byte_host`

## Requirements
- R1: During and right after reset, these outputs are all high:
  - `adc_csel_n_o`
  - `adc_start_n_o`
  - `adc_rd_n_o`
  - `adc_nap_n_o`
  - `adc_sleep_n_o`

  At the same time `adc_hibyte_o`, `res_valid_o` and `timeout_o` are low, and `req_ready_o` is high.
- R2: After an accepted request, `adc_csel_n_o` is low for exactly SETUP_CYC cycles with `adc_start_n_o` high. Then `adc_start_n_o` is low for exactly STROBE_CYC cycles. The start strobe is never low while select is high.
- R3: No read strobe is issued while `adc_busy_n_i` is low. Reading begins only after busy has been seen low and then seen high. A busy line that never goes low does not count as a completed conversion.
- R4: The high read drives `adc_hibyte_o`=1 and `adc_rd_n_o`=0 for ACCESS_CYC cycles. Data lines 3..0 become result bits 11..8, and data lines 7..4 are ignored.
- R5: After one cycle with `adc_rd_n_o` high, the low read drives `adc_hibyte_o`=0 and `adc_rd_n_o`=0 for ACCESS_CYC cycles. Data lines 7..0 become result bits 7..0.
- R6: The result is flagged by `res_valid_o` high for exactly one cycle, with `adc_csel_n_o` high in that cycle. With `bipolar_i`=0 at acceptance, `res_data_o` equals the converter's code.
- R7: With `bipolar_i`=1 at acceptance, `res_data_o` equals the converter's code with bit 11 inverted, which is the code plus 2048 modulo 4096. The mode is sampled when the request is accepted.
- R8: If busy does not complete its low-then-high cycle within BUSY_LIMIT_CYC cycles of entering the wait, `timeout_o` pulses for one cycle in the last of those cycles. The next cycle has `adc_csel_n_o` high, and no valid result is produced.
- R9: `req_i` is accepted only when `req_ready_o` is high. `req_ready_o` is high only when the sequencer is idle with no power-down request present. A request at any other time starts no conversion.
- R10: While `sleep_i` is high, `adc_sleep_n_o` is low and no conversion starts. After `sleep_i` falls, `req_ready_o` stays low until `adc_ref_ok_i` is high.
- R11: While `nap_i` is high, `adc_nap_n_o` is low. After `nap_i` falls, `req_ready_o` stays low for exactly NAP_WAKE_CYC cycles.
- R12: In idle, a sleep request outranks a nap request, and either one outranks a sample request. `adc_sleep_n_o` and `adc_nap_n_o` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Sample request |
| bipolar_i | input | 1 | 1 = return two's complement, 0 = straight binary |
| nap_i | input | 1 | Nap power-down request |
| sleep_i | input | 1 | Sleep power-down request |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 12 | Assembled result |
| timeout_o | output | 1 | One-cycle busy timeout pulse |
| adc_csel_n_o | output | 1 | Converter chip select, active low |
| adc_start_n_o | output | 1 | Conversion start strobe, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| adc_hibyte_o | output | 1 | 1 = high nibble on bus, 0 = low byte |
| adc_nap_n_o | output | 1 | Nap mode control, active low |
| adc_sleep_n_o | output | 1 | Sleep mode control, active low |
| adc_busy_n_i | input | 1 | Converter busy, low during conversion |
| adc_ref_ok_i | input | 1 | Converter reference settled |
| adc_data_i | input | 8 | Converter data bus |

## Verification
The bench builds the sequencer with these short settings:

| Parameter | Bench value |
|-----------|-------------|
| SETUP_CYC | 2 |
| STROBE_CYC | 2 |
| ACCESS_CYC | 2 |
| NAP_WAKE_CYC | 5 |
| BUSY_LIMIT_CYC | 20 |

These short windows make every strobe width, the nap wake count and the full timeout window countable cycle by cycle. They also keep each conversion to about sixteen cycles. That brings every one of the 4096 straight-binary codes within reach, plus a third of the codes and the sign-boundary codes in bipolar mode, with the busy length varied per code. The converter model puts junk on the unused high-read lines, so the masking is exercised on every conversion.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SLEEP,
        ST_REF_WAIT,
        ST_NAP,
        ST_NAP_WAKE,
        ST_SETUP,
        ST_STROBE,
        ST_BUSY_WAIT,
        ST_READ_HI,
        ST_READ_GAP,
        ST_READ_LO,
        ST_DONE
    } host_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_step_timer.sv
module adc_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_word_pack.sv
module adc_word_pack #(
    parameter int BUS_W  = 8,
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hi,
    input  logic              cap_lo,
    input  logic              bipolar,
    input  logic [BUS_W-1:0]  bus_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int HI_W = WORD_W - BUS_W;

    logic [HI_W-1:0]  hi_q;
    logic [BUS_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (cap_hi) hi_q <= bus_i[HI_W-1:0];
            if (cap_lo) lo_q <= bus_i;
        end
    end

    always_comb begin
        word_o = {hi_q, lo_q};
        word_o[WORD_W-1] = hi_q[HI_W-1] ^ bipolar;
    end

endmodule

// File: rtl/adc_byte_host.sv
module adc_byte_host
    import adc_host_pkg::*;
#(
    parameter int BUS_W          = 8,
    parameter int WORD_W         = 12,
    parameter int SETUP_CYC      = 2,
    parameter int STROBE_CYC     = 3,
    parameter int ACCESS_CYC     = 3,
    parameter int NAP_WAKE_CYC   = 124,
    parameter int BUSY_LIMIT_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              bipolar_i,
    input  logic              nap_i,
    input  logic              sleep_i,
    output logic              req_ready_o,
    output logic              res_valid_o,
    output logic [WORD_W-1:0] res_data_o,
    output logic              timeout_o,
    output logic              adc_csel_n_o,
    output logic              adc_start_n_o,
    output logic              adc_rd_n_o,
    output logic              adc_hibyte_o,
    output logic              adc_nap_n_o,
    output logic              adc_sleep_n_o,
    input  logic              adc_busy_n_i,
    input  logic              adc_ref_ok_i,
    input  logic [BUS_W-1:0]  adc_data_i
);

    localparam int MAX_CYC = max_of(max_of(SETUP_CYC, STROBE_CYC),
                                    max_of(max_of(ACCESS_CYC, NAP_WAKE_CYC), BUSY_LIMIT_CYC));
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] ACCESS_LAST = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LAST   = CNT_W'(NAP_WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] LIMIT_LAST  = CNT_W'(BUSY_LIMIT_CYC - 1);

    host_state_e      state_q, state_d;
    logic [CNT_W-1:0] step_cnt;
    logic             busy_seen_q;
    logic             mode_q;
    logic             accept;
    logic             conv_end;
    logic             cap_hi, cap_lo;

    assign accept   = (state_q == ST_IDLE) && !sleep_i && !nap_i && req_i;
    assign conv_end = busy_seen_q && adc_busy_n_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Busy low seen since strobe, and result format latched at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_seen_q <= 1'b0;
            mode_q      <= 1'b0;
        end else begin
            if (accept) mode_q <= bipolar_i;
            if (state_q == ST_STROBE || state_q == ST_BUSY_WAIT) begin
                if (!adc_busy_n_i) busy_seen_q <= 1'b1;
            end else begin
                busy_seen_q <= 1'b0;
            end
        end
    end

    adc_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .cnt   (step_cnt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sleep_i)     state_d = ST_SLEEP;
                else if (nap_i)  state_d = ST_NAP;
                else if (req_i)  state_d = ST_SETUP;
            end
            ST_SLEEP:     if (!sleep_i)                  state_d = ST_REF_WAIT;
            ST_REF_WAIT:  if (adc_ref_ok_i)              state_d = ST_IDLE;
            ST_NAP:       if (!nap_i)                    state_d = ST_NAP_WAKE;
            ST_NAP_WAKE:  if (step_cnt == WAKE_LAST)     state_d = ST_IDLE;
            ST_SETUP:     if (step_cnt == SETUP_LAST)    state_d = ST_STROBE;
            ST_STROBE:    if (step_cnt == STROBE_LAST)   state_d = ST_BUSY_WAIT;
            ST_BUSY_WAIT: begin
                if (conv_end)                     state_d = ST_READ_HI;
                else if (step_cnt == LIMIT_LAST)  state_d = ST_IDLE;
            end
            ST_READ_HI:   if (step_cnt == ACCESS_LAST)   state_d = ST_READ_GAP;
            ST_READ_GAP:                                 state_d = ST_READ_LO;
            ST_READ_LO:   if (step_cnt == ACCESS_LAST)   state_d = ST_DONE;
            ST_DONE:                                     state_d = ST_IDLE;
            default:                                     state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        req_ready_o   = 1'b0;
        res_valid_o   = 1'b0;
        timeout_o     = 1'b0;
        adc_csel_n_o  = 1'b1;
        adc_start_n_o = 1'b1;
        adc_rd_n_o    = 1'b1;
        adc_hibyte_o  = 1'b0;
        adc_nap_n_o   = 1'b1;
        adc_sleep_n_o = 1'b1;
        cap_hi        = 1'b0;
        cap_lo        = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready_o = !sleep_i && !nap_i;
            ST_SLEEP:     adc_sleep_n_o = 1'b0;
            ST_NAP:       adc_nap_n_o = 1'b0;
            ST_SETUP:     adc_csel_n_o = 1'b0;
            ST_STROBE: begin
                adc_csel_n_o  = 1'b0;
                adc_start_n_o = 1'b0;
            end
            ST_BUSY_WAIT: begin
                adc_csel_n_o = 1'b0;
                timeout_o    = !conv_end && (step_cnt == LIMIT_LAST);
            end
            ST_READ_HI: begin
                adc_csel_n_o = 1'b0;
                adc_rd_n_o   = 1'b0;
                adc_hibyte_o = 1'b1;
                cap_hi       = (step_cnt == ACCESS_LAST);
            end
            ST_READ_GAP:  adc_csel_n_o = 1'b0;
            ST_READ_LO: begin
                adc_csel_n_o = 1'b0;
                adc_rd_n_o   = 1'b0;
                cap_lo       = (step_cnt == ACCESS_LAST);
            end
            ST_DONE:      res_valid_o = 1'b1;
            default: ;
        endcase
    end

    adc_word_pack #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_hi  (cap_hi),
        .cap_lo  (cap_lo),
        .bipolar (mode_q),
        .bus_i   (adc_data_i),
        .word_o  (res_data_o)
    );

endmodule

// File: rtl/adc_host_checker.sv
module adc_host_checker (
    input logic clk,
    input logic rst_n,
    input logic req_ready_o,
    input logic res_valid_o,
    input logic timeout_o,
    input logic adc_csel_n_o,
    input logic adc_start_n_o,
    input logic adc_rd_n_o,
    input logic adc_nap_n_o,
    input logic adc_sleep_n_o
);

    assert_start_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_start_n_o |-> !adc_csel_n_o);

    assert_start_after_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_start_n_o) |-> $past(!adc_csel_n_o));

    assert_read_in_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n_o |-> (!adc_csel_n_o && adc_start_n_o));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    assert_valid_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> adc_csel_n_o);

    assert_timeout_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> (adc_csel_n_o && !res_valid_o));

    assert_timeout_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout_o && res_valid_o));

    assert_ready_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> adc_csel_n_o);

    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_sleep_n_o |-> (adc_csel_n_o && !req_ready_o));

    assert_nap_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_nap_n_o |-> (adc_csel_n_o && !req_ready_o));

    assert_power_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_sleep_n_o && !adc_nap_n_o));

endmodule

bind adc_byte_host adc_host_checker u_host_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready_o   (req_ready_o),
    .res_valid_o   (res_valid_o),
    .timeout_o     (timeout_o),
    .adc_csel_n_o  (adc_csel_n_o),
    .adc_start_n_o (adc_start_n_o),
    .adc_rd_n_o    (adc_rd_n_o),
    .adc_nap_n_o   (adc_nap_n_o),
    .adc_sleep_n_o (adc_sleep_n_o)
);

// File: tb/tb_adc_byte_host.sv
`timescale 1ns/1ps
module tb_adc_byte_host;

    localparam int SETUP  = 2;
    localparam int STROBE = 2;
    localparam int ACCESS = 2;
    localparam int WAKE   = 5;
    localparam int LIMIT  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, bipolar = 1'b0, nap = 1'b0, sleep = 1'b0;
    logic        ready, valid, tmo;
    logic [11:0] res;
    logic        csel_n, start_n, rd_n, hibyte, nap_n, sleep_n;
    logic        busy_n = 1'b1;
    logic        ref_ok = 1'b1;
    logic [7:0]  bus;

    logic [11:0] mdl_val = '0;
    int          mdl_blen = 1;
    int          mdl_hang = 0;      // 0 normal, 1 stuck low, 2 never low
    logic        ref_hold = 1'b0;
    int          busy_left = 0;
    int          proto_bad = 0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adc_byte_host #(
        .SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .ACCESS_CYC(ACCESS),
        .NAP_WAKE_CYC(WAKE), .BUSY_LIMIT_CYC(LIMIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .bipolar_i(bipolar),
        .nap_i(nap), .sleep_i(sleep), .req_ready_o(ready), .res_valid_o(valid),
        .res_data_o(res), .timeout_o(tmo), .adc_csel_n_o(csel_n),
        .adc_start_n_o(start_n), .adc_rd_n_o(rd_n), .adc_hibyte_o(hibyte),
        .adc_nap_n_o(nap_n), .adc_sleep_n_o(sleep_n), .adc_busy_n_i(busy_n),
        .adc_ref_ok_i(ref_ok), .adc_data_i(bus)
    );

    // Converter model: junk on lines 7..4 during the high read
    assign bus = (!csel_n && !rd_n)
               ? (hibyte ? {mdl_val[3:0] ^ 4'hA, mdl_val[11:8]} : mdl_val[7:0])
               : 8'hFF;

    always @(negedge clk) begin
        if (!busy_n && !rd_n) proto_bad <= proto_bad + 1;
        if (!rst_n) begin
            busy_n    <= 1'b1;
            busy_left <= 0;
        end else if (!start_n && !csel_n) begin
            if (mdl_hang != 2) busy_n <= 1'b0;
            busy_left <= mdl_blen;
        end else if (!busy_n && mdl_hang == 0) begin
            if (busy_left <= 1) busy_n <= 1'b1;
            busy_left <= busy_left - 1;
        end
        if (!sleep_n)      ref_ok <= 1'b0;
        else if (!ref_hold) ref_ok <= 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_conv(input logic [11:0] val, input bit bip, input int blen);
        int pre = 0, strb = 0, hi = 0, lo = 0, guard = 0;
        int bad0;
        bit strobe_seen = 0, got = 0;
        logic [11:0] expv;
        mdl_val  = val;
        mdl_blen = blen;
        while (!ready) @(negedge clk);
        bad0    = proto_bad;
        req     = 1'b1;
        bipolar = bip;
        @(negedge clk);
        req = 1'b0;
        while (!got && guard < 200) begin
            if (!start_n) begin strb++; strobe_seen = 1; end
            else if (!csel_n && !strobe_seen) pre++;
            if (!rd_n && hibyte)  hi++;
            if (!rd_n && !hibyte) lo++;
            if (valid) begin
                got = 1;
                expv = bip ? 12'((int'(val) + 2048) % 4096) : val;
                chk(res == expv, bip ? "R7 bipolar word" : "R6 straight word", res, expv);
                chk(csel_n == 1'b1, "R6 deselect at valid", csel_n, 1);
            end else begin
                @(negedge clk);
                guard++;
            end
        end
        chk(got, "R6 valid seen", got, 1);
        chk(pre == SETUP, "R2 select setup", pre, SETUP);
        chk(strb == STROBE, "R2 strobe width", strb, STROBE);
        chk(hi == ACCESS, "R4 high read width", hi, ACCESS);
        chk(lo == ACCESS, "R5 low read width", lo, ACCESS);
        chk(proto_bad == bad0, "R3 no read while busy", proto_bad - bad0, 0);
        @(negedge clk);
        chk(!valid, "R6 single pulse", valid, 0);
    endtask

    task automatic do_timeout(input int hang);
        int wcnt = 0, guard = 0, vcnt = 0;
        bit strobe_seen = 0, hit = 0;
        mdl_hang = hang;
        while (!ready) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        while (!hit && guard < 100) begin
            if (!start_n) strobe_seen = 1;
            else if (strobe_seen && !csel_n) wcnt++;
            if (valid) vcnt++;
            if (tmo) hit = 1;
            else begin @(negedge clk); guard++; end
        end
        chk(hit, "R8 timeout raised", hit, 1);
        chk(wcnt == LIMIT, "R8 timeout window", wcnt, LIMIT);
        @(negedge clk);
        chk(csel_n && !tmo, "R8 released after timeout", csel_n, 1);
        chk(vcnt == 0 && !valid, "R8 no result", vcnt, 0);
        mdl_hang = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int waits, starts, vals, bad;
        bit prev_start;
        repeat (3) @(negedge clk);
        chk(csel_n && start_n && rd_n && nap_n && sleep_n && !hibyte && !valid && !tmo,
            "R1 reset outputs", {csel_n, start_n, rd_n, nap_n, sleep_n}, 31);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && csel_n && !valid, "R1 idle after reset", ready, 1);

        // Exhaustive straight-binary sweep
        for (int v = 0; v < 4096; v++) do_conv(12'(v), 1'b0, (v % 4) + 1);
        // Bipolar sweep with sign-boundary corners
        for (int v = 0; v < 4096; v += 3) do_conv(12'(v), 1'b1, (v % 3) + 1);
        do_conv(12'h7FF, 1'b1, 2);
        do_conv(12'h800, 1'b1, 2);
        do_conv(12'hFFF, 1'b1, 1);

        // R8 and R3: busy stuck low, then busy never going low
        do_timeout(1);
        do_timeout(2);
        do_conv(12'h5A3, 1'b0, 2);

        // R9: request held during a conversion starts nothing extra
        while (!ready) @(negedge clk);
        mdl_val = 12'h321; mdl_blen = 2;
        req = 1'b1; bipolar = 1'b0;
        @(negedge clk);
        starts = 0; vals = 0; prev_start = start_n;
        for (int i = 0; i < 6; i++) begin
            if (!start_n && prev_start) starts++;
            prev_start = start_n;
            @(negedge clk);
        end
        req = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (!start_n && prev_start) starts++;
            prev_start = start_n;
            if (valid) vals++;
            @(negedge clk);
        end
        chk(starts == 1, "R9 one start", starts, 1);
        chk(vals == 1, "R9 one result", vals, 1);

        // R10 and R12: sleep with nap and request present
        sleep = 1'b1; nap = 1'b1; ref_hold = 1'b1; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk(!sleep_n, "R10 sleep driven", sleep_n, 0);
        chk(nap_n && csel_n, "R12 sleep outranks", nap_n, 1);
        chk(!ready, "R10 not ready asleep", ready, 0);
        req = 1'b1;
        bad = 0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); if (!csel_n) bad++; end
        req = 1'b0;
        chk(bad == 0, "R10 request ignored asleep", bad, 0);
        sleep = 1'b0; nap = 1'b0;
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ready || !sleep_n) bad++;
        end
        chk(bad == 0, "R10 hold until reference", bad, 0);
        ref_hold = 1'b0;
        waits = 0;
        while (!ready && waits < 5) begin @(negedge clk); waits++; end
        chk(ready, "R10 ready after reference", ready, 1);
        do_conv(12'hABC, 1'b0, 3);

        // R12: nap outranks a simultaneous request
        nap = 1'b1; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(!nap_n && csel_n && sleep_n, "R12 nap over request", nap_n, 0);
        @(negedge clk);
        chk(!nap_n && !ready, "R11 nap held", nap_n, 0);
        nap = 1'b0;
        waits = 0;
        @(negedge clk);
        while (!ready && waits < 50) begin waits++; @(negedge clk); end
        chk(waits == WAKE, "R11 wake cycles", waits, WAKE);
        chk(nap_n, "R11 nap released", nap_n, 1);
        do_conv(12'h0F0, 1'b1, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule